// File: doc/BRIEF.md
# Frequency Synthesizer Command Register Decoder

This block sits behind a byte-level two-wire slave and turns its byte stream into register updates for a programmable clock synthesizer. After each start condition in the write direction, the first byte is a command code that selects a register. The bytes that follow are write data. After a repeated start in the read direction, the block presents read bytes for the selected register one at a time. The slave advances through them with a per-byte strobe.

The block holds five settings:
- a ten-bit oscillator trim word;
- a five-bit band offset;
- a ten-bit output divider word;
- a ten-bit output-routing word;
- a four-bit address field whose top bit is the commit policy bit.

It also returns a fixed fourteen-bit read-only band word, whose top five bits carry the default band offset.

Each completed write can request a save of all settings to nonvolatile storage, according to the commit policy bit. The save request is a handshake with a storage model that reports when it is busy. A save requested while one is already pending or in progress is merged into a single pending request. That request is issued once the busy indication drops.

Top module: `synth_cmd_decoder`

## Requirements
- R1: After reset the trim word is DAC_RST (500), the band offset is DEF_OFFSET (12), the divider word is 0, the routing word is 10'h060, the address field is 0, and commit_req is low.
- R2: Command codes select registers as follows: 08h trim word, 01h divider word, 02h routing word, 0Eh band offset, 0Dh address field. A ten-bit register takes two data bytes. The first byte supplies bits 9:2. Bits 7:6 of the second byte supply bits 1:0, and bits 5:0 of the second byte are ignored.
- R3: A ten-bit register reads back as two bytes: value[9:2], then {value[1:0], 000000}. Any read byte past a register's length returns FFh.
- R4: The band offset takes the low 5 bits of its single data byte and reads back as {111, offset}. The address field takes the low 4 bits and reads back as {0000, field}. Bit 3 of the address field is the commit policy bit WC.
- R5: Command 37h reads the range word R, which is {DEF_OFFSET, RANGE_TAIL}, as the bytes R[13:6] and then {R[5:0], 00}. A write under 37h, or under any unknown code, changes no register. A read under an unknown code returns FFh.
- R6: A register changes only when its last data byte arrives. A stop condition or a new start condition after only part of a two-byte write discards the partial value.
- R7: Bit 9 of the routing word is always stored as 0, whatever is written. Bits 8:0 take the written value.
- R8: With WC = 0, each completed register write produces one save request. With WC = 1, completed writes to registers other than the address field produce none.
- R9: Command 3Fh produces one save request regardless of WC.
- R10: A completed write to the address field produces one save request regardless of WC.
- R11: While pwr_down is high, command and data bytes are ignored: no register changes and no save is requested.
- R12: commit_req is never high while commit_busy is high. Requests that arrive while a save is pending or busy merge into one request, which is issued after busy clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Start in the write direction; the next byte is a command |
| rd_start | input | 1 | Repeated start in the read direction; the read index returns to 0 |
| bus_stop | input | 1 | Stop condition; ends the transfer and drops any partial write |
| wr_valid | input | 1 | A byte from the master is present on wr_byte |
| wr_byte | input | 8 | Received byte |
| rd_next | input | 1 | The current read byte has been consumed; advance to the next |
| rd_data | output | 8 | Current read byte |
| pwr_down | input | 1 | Device is powered down; writes are refused |
| commit_req | output | 1 | Single-cycle request to save all settings |
| commit_busy | input | 1 | Storage model is saving |
| dac_word | output | 10 | Oscillator trim word |
| offset_word | output | 5 | Band offset |
| div_word | output | 10 | Output divider word |
| mux_word | output | 10 | Output routing word |
| addr_word | output | 4 | Address field; bit 3 is WC |

## Verification
The bench sweeps every value of the trim word and the routing word, and a spread of divider values. It also sweeps every byte into the band offset and the address field, checking each stored value and its read-back bytes. These sweeps would catch a decoder that swapped the two data bytes, kept the ignored low bits, failed to clear routing bit 9, or read back the wrong pad bits.

The save checks count requests after each of these cases:
- a write with WC = 0;
- a write with WC = 1;
- command 3Fh;
- an address write under either policy;
- a burst of writes while the store is busy.

A design that missed the forced address save, or failed to merge a burst into one request, would show a wrong count. A design that raised commit_req during busy would be caught by an overlap counter.

Partial writes cut short by a stop, writes while powered down, and writes to the range code or an unknown code must leave every register unchanged. A design that latched the first byte early or failed to gate power-down would alter a register.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int WIDE_W = 10;
    localparam int OFS_W  = 5;
    localparam int ADR_W  = 4;
    localparam int RNG_W  = 14;
    localparam int IDX_W  = 2;
    localparam int PAD_W  = BYTE_W - (WIDE_W - BYTE_W);
    localparam int RNG_LO = RNG_W - BYTE_W;

    localparam logic [BYTE_W-1:0] CODE_DAC  = 8'h08;
    localparam logic [BYTE_W-1:0] CODE_OFS  = 8'h0E;
    localparam logic [BYTE_W-1:0] CODE_DIV  = 8'h01;
    localparam logic [BYTE_W-1:0] CODE_MUX  = 8'h02;
    localparam logic [BYTE_W-1:0] CODE_ADR  = 8'h0D;
    localparam logic [BYTE_W-1:0] CODE_RNG  = 8'h37;
    localparam logic [BYTE_W-1:0] CODE_SAVE = 8'h3F;

    localparam logic [WIDE_W-1:0] MUX_RST = 10'h060;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_DAC, SEL_OFS, SEL_DIV, SEL_MUX, SEL_ADR, SEL_RNG, SEL_SAVE
    } sel_e;

    typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_DATA} phase_e;

    typedef struct packed {
        logic              valid;
        sel_e              sel;
        logic [WIDE_W-1:0] value;
    } upd_t;

    typedef struct packed {
        logic [WIDE_W-1:0] dac;
        logic [OFS_W-1:0]  ofs;
        logic [WIDE_W-1:0] div;
        logic [WIDE_W-1:0] mux;
        logic [ADR_W-1:0]  adr;
    } regs_t;

    function automatic sel_e decode_cmd(input logic [BYTE_W-1:0] code);
        case (code)
            CODE_DAC:  return SEL_DAC;
            CODE_OFS:  return SEL_OFS;
            CODE_DIV:  return SEL_DIV;
            CODE_MUX:  return SEL_MUX;
            CODE_ADR:  return SEL_ADR;
            CODE_RNG:  return SEL_RNG;
            CODE_SAVE: return SEL_SAVE;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic is_wide(input sel_e s);
        return (s == SEL_DAC) || (s == SEL_DIV) || (s == SEL_MUX);
    endfunction

    function automatic logic is_narrow(input sel_e s);
        return (s == SEL_OFS) || (s == SEL_ADR);
    endfunction

    function automatic logic [BYTE_W-1:0] wide_byte(input logic [WIDE_W-1:0] v,
                                                    input logic [IDX_W-1:0] idx);
        if (idx == 2'd0) return v[WIDE_W-1:WIDE_W-BYTE_W];
        if (idx == 2'd1) return {v[WIDE_W-BYTE_W-1:0], {PAD_W{1'b0}}};
        return IDLE_BYTE;
    endfunction

    function automatic logic [BYTE_W-1:0] read_byte(input sel_e s,
                                                    input logic [IDX_W-1:0] idx,
                                                    input regs_t r,
                                                    input logic [RNG_W-1:0] rng);
        case (s)
            SEL_DAC: return wide_byte(r.dac, idx);
            SEL_DIV: return wide_byte(r.div, idx);
            SEL_MUX: return wide_byte(r.mux, idx);
            SEL_OFS: return (idx == 2'd0) ? {{(BYTE_W-OFS_W){1'b1}}, r.ofs} : IDLE_BYTE;
            SEL_ADR: return (idx == 2'd0) ? {{(BYTE_W-ADR_W){1'b0}}, r.adr} : IDLE_BYTE;
            SEL_RNG: begin
                if (idx == 2'd0) return rng[RNG_W-1:RNG_LO];
                if (idx == 2'd1) return {rng[RNG_LO-1:0], {(BYTE_W-RNG_LO){1'b0}}};
                return IDLE_BYTE;
            end
            default: return IDLE_BYTE;
        endcase
    endfunction

endpackage

// File: rtl/cmd_tracker.sv
module cmd_tracker
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_start,
    input  logic              rd_start,
    input  logic              bus_stop,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              pwr_down,
    output upd_t              upd,
    output logic              save_pulse,
    output sel_e              cur_sel
);

    phase_e            phase_q;
    sel_e              sel_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] hold_q;
    logic              accept;
    logic              last_byte;

    assign accept    = wr_valid && !pwr_down && !bus_stop && !xfer_start && !rd_start;
    assign last_byte = (is_wide(sel_q) && idx_q == 2'd1) ||
                       (is_narrow(sel_q) && idx_q == 2'd0);

    always_comb begin
        upd.valid = accept && (phase_q == PH_DATA) && last_byte;
        upd.sel   = sel_q;
        if (is_wide(sel_q))
            upd.value = {hold_q, wr_byte[BYTE_W-1:BYTE_W-(WIDE_W-BYTE_W)]};
        else
            upd.value = {{(WIDE_W-BYTE_W){1'b0}}, wr_byte};
    end

    assign save_pulse = accept && (phase_q == PH_CMD) && (decode_cmd(wr_byte) == SEL_SAVE);
    assign cur_sel    = sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            sel_q   <= SEL_NONE;
            idx_q   <= '0;
            hold_q  <= '0;
        end else if (xfer_start) begin
            phase_q <= PH_CMD;
            idx_q   <= '0;
        end else if (bus_stop || rd_start) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else if (accept) begin
            if (phase_q == PH_CMD) begin
                sel_q   <= decode_cmd(wr_byte);
                phase_q <= PH_DATA;
                idx_q   <= '0;
            end else if (phase_q == PH_DATA) begin
                if (idx_q == 2'd0)
                    hold_q <= wr_byte;
                if (idx_q != 2'd2)
                    idx_q <= idx_q + 2'd1;
            end
        end
    end

endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import synth_cfg_pkg::*;
#(
    parameter logic [WIDE_W-1:0] DAC_RST = 10'd500,
    parameter logic [WIDE_W-1:0] DIV_RST = 10'd0,
    parameter logic [OFS_W-1:0]  OFS_RST = 5'd12
) (
    input  logic  clk,
    input  logic  rst,
    input  upd_t  upd,
    output regs_t regs
);

    regs_t regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.dac <= DAC_RST;
            regs_q.ofs <= OFS_RST;
            regs_q.div <= DIV_RST;
            regs_q.mux <= MUX_RST;
            regs_q.adr <= '0;
        end else if (upd.valid) begin
            case (upd.sel)
                SEL_DAC: regs_q.dac <= upd.value;
                SEL_DIV: regs_q.div <= upd.value;
                SEL_MUX: regs_q.mux <= {1'b0, upd.value[WIDE_W-2:0]};
                SEL_OFS: regs_q.ofs <= upd.value[OFS_W-1:0];
                SEL_ADR: regs_q.adr <= upd.value[ADR_W-1:0];
                default: ;
            endcase
        end
    end

    assign regs = regs_q;

    assert_mux_msb_R7: assert property (@(posedge clk) disable iff (rst)
        (upd.valid && upd.sel == SEL_MUX) |=>
            (regs_q.mux == {1'b0, $past(upd.value[WIDE_W-2:0])}))
        else $error("routing word bit 9 not cleared");

endmodule

// File: rtl/commit_ctl.sv
module commit_ctl
    import synth_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  upd_t upd,
    input  logic save_pulse,
    input  logic wc,
    input  logic commit_busy,
    output logic commit_req
);

    logic pend_q;
    logic trig;

    assign trig = save_pulse ||
                  (upd.valid && ((upd.sel == SEL_ADR) || !wc));

    assign commit_req = pend_q && !commit_busy;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else
            pend_q <= (pend_q && !commit_req) || trig;
    end

    assert_req_once_R12: assert property (@(posedge clk) disable iff (rst)
        (commit_req && !trig) |=> !commit_req)
        else $error("save request repeated without a new cause");

endmodule

// File: rtl/rd_port.sv
module rd_port
    import synth_cfg_pkg::*;
#(
    parameter logic [RNG_W-1:0] RANGE_WORD = 14'h18A5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_start,
    input  logic              rd_next,
    input  sel_e              sel,
    input  regs_t             regs,
    output logic [BYTE_W-1:0] rd_data
);

    logic [IDX_W-1:0] ridx_q;

    always_ff @(posedge clk) begin
        if (rst || rd_start)
            ridx_q <= '0;
        else if (rd_next && ridx_q != 2'd2)
            ridx_q <= ridx_q + 2'd1;
    end

    assign rd_data = read_byte(sel, ridx_q, regs, RANGE_WORD);

endmodule

// File: rtl/synth_cmd_decoder.sv
module synth_cmd_decoder
    import synth_cfg_pkg::*;
#(
    parameter logic [WIDE_W-1:0]      DAC_RST    = 10'd500,
    parameter logic [WIDE_W-1:0]      DIV_RST    = 10'd0,
    parameter logic [OFS_W-1:0]       DEF_OFFSET = 5'd12,
    parameter logic [RNG_W-OFS_W-1:0] RANGE_TAIL = 9'h0A5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        xfer_start,
    input  logic        rd_start,
    input  logic        bus_stop,
    input  logic        wr_valid,
    input  logic [7:0]  wr_byte,
    input  logic        rd_next,
    output logic [7:0]  rd_data,
    input  logic        pwr_down,
    output logic        commit_req,
    input  logic        commit_busy,
    output logic [9:0]  dac_word,
    output logic [4:0]  offset_word,
    output logic [9:0]  div_word,
    output logic [9:0]  mux_word,
    output logic [3:0]  addr_word
);

    localparam logic [RNG_W-1:0] RANGE_WORD = {DEF_OFFSET, RANGE_TAIL};

    upd_t  upd;
    logic  save_pulse;
    sel_e  cur_sel;
    regs_t regs;

    cmd_tracker u_trk (
        .clk        (clk),
        .rst        (rst),
        .xfer_start (xfer_start),
        .rd_start   (rd_start),
        .bus_stop   (bus_stop),
        .wr_valid   (wr_valid),
        .wr_byte    (wr_byte),
        .pwr_down   (pwr_down),
        .upd        (upd),
        .save_pulse (save_pulse),
        .cur_sel    (cur_sel)
    );

    reg_bank #(
        .DAC_RST (DAC_RST),
        .DIV_RST (DIV_RST),
        .OFS_RST (DEF_OFFSET)
    ) u_regs (
        .clk  (clk),
        .rst  (rst),
        .upd  (upd),
        .regs (regs)
    );

    commit_ctl u_commit (
        .clk         (clk),
        .rst         (rst),
        .upd         (upd),
        .save_pulse  (save_pulse),
        .wc          (regs.adr[ADR_W-1]),
        .commit_busy (commit_busy),
        .commit_req  (commit_req)
    );

    rd_port #(
        .RANGE_WORD (RANGE_WORD)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_start (rd_start),
        .rd_next  (rd_next),
        .sel      (cur_sel),
        .regs     (regs),
        .rd_data  (rd_data)
    );

    assign dac_word    = regs.dac;
    assign offset_word = regs.ofs;
    assign div_word    = regs.div;
    assign mux_word    = regs.mux;
    assign addr_word   = regs.adr;

    assert_pwrdn_hold_R11: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> ($stable(dac_word) && $stable(offset_word) && $stable(div_word) &&
                      $stable(mux_word) && $stable(addr_word)))
        else $error("register changed while powered down");

    assert_stop_hold_R6: assert property (@(posedge clk) disable iff (rst)
        bus_stop |=> ($stable(dac_word) && $stable(div_word) && $stable(mux_word)))
        else $error("register changed on a stop condition");

endmodule

// File: tb/synth_cmd_decoder_test.sv
module synth_cmd_decoder_test;

    localparam int DAC_R  = 500;
    localparam int OFS_R  = 12;
    localparam int TAIL   = 'h0A5;
    localparam int RANGE  = (OFS_R << 9) | TAIL;
    localparam int BUSY_N = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xfer_start = 1'b0, rd_start = 1'b0, bus_stop = 1'b0;
    logic       wr_valid = 1'b0, rd_next = 1'b0, pwr_down = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic [7:0] rd_data;
    logic       commit_req;
    logic       commit_busy;
    logic [9:0] dac_word, div_word, mux_word;
    logic [4:0] offset_word;
    logic [3:0] addr_word;

    int n_tests = 0;
    int n_fail  = 0;
    int n_commit = 0;
    int n_overlap = 0;
    int busy_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    synth_cmd_decoder uut (
        .clk(clk), .rst(rst), .xfer_start(xfer_start), .rd_start(rd_start),
        .bus_stop(bus_stop), .wr_valid(wr_valid), .wr_byte(wr_byte),
        .rd_next(rd_next), .rd_data(rd_data), .pwr_down(pwr_down),
        .commit_req(commit_req), .commit_busy(commit_busy),
        .dac_word(dac_word), .offset_word(offset_word), .div_word(div_word),
        .mux_word(mux_word), .addr_word(addr_word)
    );

    // storage stub: busy for BUSY_N cycles after each accepted request
    always @(posedge clk) begin
        if (rst) begin
            commit_busy <= 1'b0;
            busy_cnt    <= 0;
        end else if (commit_busy) begin
            if (busy_cnt == 0) commit_busy <= 1'b0;
            else busy_cnt <= busy_cnt - 1;
        end else if (commit_req) begin
            commit_busy <= 1'b1;
            busy_cnt    <= BUSY_N;
        end
    end

    always @(negedge clk) begin
        if (!rst && commit_req) n_commit++;
        if (!rst && commit_req && commit_busy) n_overlap++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sendb(input logic [7:0] b);
        wr_valid = 1'b1; wr_byte = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic start_w();
        xfer_start = 1'b1; @(negedge clk); xfer_start = 1'b0;
    endtask

    task automatic stop_b();
        bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic write1(input logic [7:0] cmd, input logic [7:0] b);
        start_w(); sendb(cmd); sendb(b); stop_b();
    endtask

    task automatic write2(input logic [7:0] cmd, input int v);
        start_w(); sendb(cmd); sendb(8'((v >> 2) & 255)); sendb(8'(((v & 3) << 6) | 'h15)); stop_b();
    endtask

    task automatic read3(input logic [7:0] cmd, output int b0, output int b1, output int b2);
        start_w(); sendb(cmd);
        rd_start = 1'b1; @(negedge clk); rd_start = 1'b0;
        b0 = rd_data;
        rd_next = 1'b1; @(negedge clk); rd_next = 1'b0;
        b1 = rd_data;
        rd_next = 1'b1; @(negedge clk); rd_next = 1'b0;
        b2 = rd_data;
        stop_b();
    endtask

    task automatic settle();
        repeat (60) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int b0, b1, b2, c0, d0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        chk("R1 dac", dac_word, DAC_R);
        chk("R1 ofs", offset_word, OFS_R);
        chk("R1 div", div_word, 0);
        chk("R1 mux", mux_word, 'h060);
        chk("R1 adr", addr_word, 0);
        chk("R1 req", commit_req, 0);

        // R5 unknown code and range code writes ignored, reads
        c0 = n_commit;
        write2(8'h55, 'h3FF);
        write2(8'h37, 'h2AA);
        settle();
        chk("R5 dac kept", dac_word, DAC_R);
        chk("R5 div kept", div_word, 0);
        chk("R5 mux kept", mux_word, 'h060);
        chk("R5 ofs kept", offset_word, OFS_R);
        read3(8'h55, b0, b1, b2);
        chk("R5 unknown b0", b0, 'hFF);
        chk("R5 unknown b1", b1, 'hFF);
        read3(8'h37, b0, b1, b2);
        chk("R5 range b0", b0, (RANGE >> 6) & 255);
        chk("R5 range b1", b1, (RANGE & 63) << 2);
        chk("R3 range past end", b2, 'hFF);

        // R8 WC=0 auto commit
        c0 = n_commit;
        write2(8'h08, 'h155);
        settle();
        chk("R8 wc0 commit", n_commit - c0, 1);
        chk("R2 dac write", dac_word, 'h155);

        // R12 merge during busy
        c0 = n_commit;
        write2(8'h08, 'h0F0);
        write1(8'h0E, 8'h07);
        write2(8'h01, 'h123);
        settle();
        chk("R12 merged", n_commit - c0, 2);

        // R10 address write with WC becoming 1
        c0 = n_commit;
        write1(8'h0D, 8'hF8);
        settle();
        chk("R10 adr commit", n_commit - c0, 1);
        chk("R4 adr", addr_word, 8);

        // R8 WC=1 no auto commit
        c0 = n_commit;
        write2(8'h02, 'h011);
        settle();
        chk("R8 wc1 none", n_commit - c0, 0);

        // R9 save command
        c0 = n_commit;
        start_w(); sendb(8'h3F); stop_b();
        settle();
        chk("R9 save cmd", n_commit - c0, 1);

        // R10 address write while WC=1
        c0 = n_commit;
        write1(8'h0D, 8'h0B);
        settle();
        chk("R10 adr commit wc1", n_commit - c0, 1);

        // R6 partial writes discarded
        d0 = dac_word;
        start_w(); sendb(8'h08); sendb(8'hAA); stop_b();
        chk("R6 stop partial", dac_word, d0);
        start_w(); sendb(8'h08); sendb(8'hAA); start_w(); sendb(8'hC0); stop_b();
        chk("R6 restart partial", dac_word, d0);

        // R11 power down
        c0 = n_commit;
        pwr_down = 1'b1;
        write2(8'h08, 'h3C3);
        write1(8'h0D, 8'h00);
        start_w(); sendb(8'h3F); stop_b();
        pwr_down = 1'b0;
        settle();
        chk("R11 dac kept", dac_word, d0);
        chk("R11 adr kept", addr_word, 'hB);
        chk("R11 no commit", n_commit - c0, 0);

        // sweeps with WC=1
        c0 = n_commit;
        for (int v = 0; v < 1024; v++) begin
            write2(8'h08, v);
            read3(8'h08, b0, b1, b2);
            chk("R2 dac sweep", dac_word, v);
            chk("R3 dac b0", b0, v >> 2);
            chk("R3 dac b1", b1, (v & 3) << 6);
            chk("R3 dac b2", b2, 'hFF);
        end
        for (int v = 0; v < 1024; v++) begin
            write2(8'h02, v);
            read3(8'h02, b0, b1, b2);
            chk("R7 mux sweep", mux_word, v & 'h1FF);
            chk("R7 mux b0", b0, (v & 'h1FF) >> 2);
            chk("R3 mux b1", b1, (v & 3) << 6);
        end
        for (int v = 0; v < 1024; v += 7) begin
            write2(8'h01, v);
            read3(8'h01, b0, b1, b2);
            chk("R2 div sweep", div_word, v);
            chk("R3 div b0", b0, v >> 2);
        end
        for (int v = 0; v < 256; v++) begin
            write1(8'h0E, 8'(v));
            read3(8'h0E, b0, b1, b2);
            chk("R4 ofs sweep", offset_word, v & 31);
            chk("R4 ofs b0", b0, 'hE0 | (v & 31));
            chk("R3 ofs b1", b1, 'hFF);
        end
        settle();
        chk("R8 wc1 sweep none", n_commit - c0, 0);
        for (int v = 0; v < 256; v++) begin
            write1(8'h0D, 8'(v));
            read3(8'h0D, b0, b1, b2);
            chk("R4 adr sweep", addr_word, v & 15);
            chk("R4 adr b0", b0, v & 15);
        end
        settle();
        chk("R12 no req during busy", n_overlap, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule